// File: doc/BRIEF.md
# Interrupt Controller Host Register Front End

This block is the host-facing write and read port of an eight-line interrupt controller. The host writes bytes over an 8-bit bus qualified by a single address bit. The block first accepts a fixed initialization series of two to four bytes. The first byte of that series decides whether the optional third and fourth bytes are expected at all. Once the series is complete, every later write is an operating command: a mask load, an end-of-interrupt or rotation command, or a status-selection and special-mask command.

The block holds every configuration field and passes it to the priority core beside it. When the first initialization byte arrives, it loads that core's reset defaults. It pulses a one-cycle strobe carrying each end-of-interrupt or rotation command. Host reads are combinational. Address 1 returns the mask. Address 0 returns either the pending-request vector or the in-service vector supplied by the core, depending on the last status selection.

All register updates take effect on the rising clock edge that samples `wr_en`. Reset is synchronous and active low. After reset the block is uninitialized, every field is zero and the lowest-priority line is 7.

Top module: `pic_cfg_front`

## Requirements
- R1: A write with `addr`=0 and `wdata[4]`=1 is always the first initialization byte, in any state, including halfway through a series and after initialization. It restarts the series, and `init_done` reads 0 on the next cycle.
- R2: The first byte stores `wdata[3]` as `level_mode`, `wdata[2]` as `intv4` and `wdata[1]` as `single_mode`. It also stores `wdata[0]` as the flag that demands a fourth byte.
- R3: The first byte also loads these defaults: `mask_bits`=0, `lowest_prio`=7, `casc_cfg`=8'h07, `special_mask`=0 and `rd_isr_sel`=0 (request vector selected for reads).
- R4: The next `addr`=1 write after the first byte is the second byte. It loads `vec_base` from `wdata[7:3]`.
- R5: A third byte (`addr`=1) is expected only when `single_mode`=0, and it loads `casc_cfg` with the whole byte. When `single_mode`=1 this step is skipped.
- R6: A fourth byte (`addr`=1) is expected only when the fourth-byte flag is 1. It loads `nest_special`=`wdata[4]`, `buffered`=`wdata[3]`, `master_sel`=`wdata[2]`, `auto_eoi`=`wdata[1]` and `cpu_mode`=`wdata[0]`. These five fields are cleared by the first byte, so they stay 0 whenever the fourth byte is skipped.
- R7: `init_done` rises after the last expected byte. Before that, an `addr`=1 write is consumed as an initialization byte or ignored, and it never changes `mask_bits`. After that, an `addr`=1 write loads `mask_bits` with the whole byte.
- R8: After initialization, an `addr`=0 write with `wdata[4:3]`=00 pulses `cmd_strobe` for one cycle. `cmd_code` takes `wdata[7:5]` and `cmd_level` takes `wdata[2:0]`, and both hold until the next such command. When `wdata[7:6]`=11 (for example 8'hE4: rotate, specific, end-of-interrupt, level 4), `lowest_prio` takes `wdata[2:0]`.
- R9: After initialization, an `addr`=0 write with `wdata[4:3]`=01 is a selection command. If `wdata[6]`=1, `special_mask` takes `wdata[5]`. If `wdata[1]`=1, `rd_isr_sel` takes `wdata[0]`. So 8'h6A selects the request vector and 8'h6B selects the in-service vector.
- R10: `rdata` is combinational. It returns `mask_bits` when `addr`=1, `srv_vec` when `addr`=0 and `rd_isr_sel`=1, and `req_vec` otherwise.
- R11: Before initialization completes, an `addr`=0 write with `wdata[4]`=0 changes no output and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write qualifier |
| addr | input | 1 | Host address bit |
| wdata | input | 8 | Host write byte |
| req_vec | input | 8 | Pending-request vector from the priority core |
| srv_vec | input | 8 | In-service vector from the priority core |
| rdata | output | 8 | Host read byte |
| init_done | output | 1 | Initialization series complete |
| level_mode | output | 1 | Level-sensitive request inputs |
| intv4 | output | 1 | Four-byte call address interval |
| single_mode | output | 1 | Single controller, no cascade |
| vec_base | output | 5 | Upper bits of the interrupt type |
| casc_cfg | output | 8 | Cascade configuration byte |
| nest_special | output | 1 | Special fully nested mode |
| buffered | output | 1 | Buffered bus mode |
| master_sel | output | 1 | Master role in buffered mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| cpu_mode | output | 1 | Processor mode select |
| mask_bits | output | 8 | Per-line mask |
| lowest_prio | output | 3 | Line holding the lowest priority |
| special_mask | output | 1 | Special mask mode enabled |
| rd_isr_sel | output | 1 | Address-0 reads return the in-service vector |
| cmd_strobe | output | 1 | One-cycle pulse per end-of-interrupt/rotation command |
| cmd_code | output | 3 | Command type bits of the last such command |
| cmd_level | output | 3 | Level field of the last such command |

## Verification
The series is driven through all four routes:
- single without a fourth byte,
- single with a fourth byte,
- cascaded without a fourth byte,
- cascaded with a fourth byte.

This separates a skipped step from a consumed one, because a wrongly expected byte would land in `casc_cfg` or in the mode flags instead of `mask_bits`. Restarts issued mid-series and after initialization show that the defaults reload and that stale mode flags are cleared. Writes made before initialization, with the address bit high and low, show that no stray command or mask load gets through. Random byte streams, with first bytes mixed in at a fixed rate, then reach command and restart orderings that the directed cases miss. After every write, each output is compared against a model kept in the bench.

// File: rtl/pic_cfg_pkg.sv
// Package: shared widths, field positions and sequencer state type for the
// interrupt controller host front end. Assumes an 8-line controller.
package pic_cfg_pkg;
    localparam int LINES   = 8;
    localparam int DW      = LINES;          // host bus width equals line count
    localparam int LVL_W   = $clog2(LINES);  // width of a line number
    localparam int VB_W    = DW - LVL_W;     // interrupt type bits above the line number
    localparam int CODE_W  = 3;              // command type field width

    // bit positions inside written bytes
    localparam int B_FIRST = 4;              // marks a first initialization byte
    localparam int B_LVL   = 3;
    localparam int B_INTV  = 2;
    localparam int B_SNGL  = 1;
    localparam int B_NEED4 = 0;

    localparam logic [LVL_W-1:0] LOWEST_DEFAULT = LVL_W'(LINES - 1);
    localparam logic [DW-1:0]    CASC_DEFAULT   = DW'(LINES - 1);

    typedef enum logic [2:0] {
        S_UNINIT = 3'd0,
        S_WAIT2  = 3'd1,
        S_WAIT3  = 3'd2,
        S_WAIT4  = 3'd3,
        S_READY  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/pic_cfg_seq.sv
// Module: initialization sequencer. It classifies each host write, and it walks
// the mandatory byte series, skipping the third and fourth steps as the
// stored first-byte flags direct. Assumes single_mode and need4 are the
// registered copies captured on the first byte.
module pic_cfg_seq
    import pic_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [1:0] dsel,        // write byte bits 4:3
    input  logic       single_mode,
    input  logic       need4,
    output seq_state_t state,
    output logic       w1_hit,
    output logic       w2_hit,
    output logic       w3_hit,
    output logic       w4_hit,
    output logic       mask_hit,
    output logic       rot_hit,
    output logic       sel_hit
);
    seq_state_t state_nx;

    // purpose: decode which register a write addresses in the current state
    always_comb begin
        w1_hit   = wr_en && !addr && dsel[1];
        w2_hit   = wr_en && addr && (state == S_WAIT2);
        w3_hit   = wr_en && addr && (state == S_WAIT3);
        w4_hit   = wr_en && addr && (state == S_WAIT4);
        mask_hit = wr_en && addr && (state == S_READY);
        rot_hit  = wr_en && !addr && (state == S_READY) && (dsel == 2'b00);
        sel_hit  = wr_en && !addr && (state == S_READY) && (dsel == 2'b01);
    end

    // purpose: next state, with optional steps skipped by the stored flags
    always_comb begin
        state_nx = state;
        if (w1_hit)
            state_nx = S_WAIT2;
        else if (w2_hit)
            state_nx = !single_mode ? S_WAIT3 : (need4 ? S_WAIT4 : S_READY);
        else if (w3_hit)
            state_nx = need4 ? S_WAIT4 : S_READY;
        else if (w4_hit)
            state_nx = S_READY;
    end

    // purpose: state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_UNINIT;
        else        state <= state_nx;
    end

    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && dsel[1]) |=> (state == S_WAIT2));

    assert_skip_third_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT2 && wr_en && addr && single_mode) |=> (state != S_WAIT3));

    assert_no_fourth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT2 && wr_en && addr && single_mode && !need4) |=> (state == S_READY));
endmodule

// File: rtl/pic_cfg_init_regs.sv
// Module: initialization registers. It captures the first through fourth bytes
// and clears the fourth-byte fields whenever a new series starts. Assumes the
// hit strobes are mutually exclusive, as the sequencer guarantees.
module pic_cfg_init_regs
    import pic_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            w1_hit,
    input  logic            w2_hit,
    input  logic            w3_hit,
    input  logic            w4_hit,
    input  logic [DW-1:0]   wdata,
    output logic            level_mode,
    output logic            intv4,
    output logic            single_mode,
    output logic            need4,
    output logic [VB_W-1:0] vec_base,
    output logic [DW-1:0]   casc_cfg,
    output logic            nest_special,
    output logic            buffered,
    output logic            master_sel,
    output logic            auto_eoi,
    output logic            cpu_mode
);
    // purpose: first-byte flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_mode  <= 1'b0;
            intv4       <= 1'b0;
            single_mode <= 1'b0;
            need4       <= 1'b0;
        end else if (w1_hit) begin
            level_mode  <= wdata[B_LVL];
            intv4       <= wdata[B_INTV];
            single_mode <= wdata[B_SNGL];
            need4       <= wdata[B_NEED4];
        end
    end

    // purpose: interrupt type base from the second byte
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_base <= '0;
        else if (w2_hit) vec_base <= wdata[DW-1:LVL_W];
    end

    // purpose: cascade byte, defaulted by a first byte, loaded by a third
    always_ff @(posedge clk) begin
        if (!rst_n)      casc_cfg <= '0;
        else if (w1_hit) casc_cfg <= CASC_DEFAULT;
        else if (w3_hit) casc_cfg <= wdata;
    end

    // purpose: fourth-byte modes, cleared at every series start
    always_ff @(posedge clk) begin
        if (!rst_n || w1_hit) begin
            nest_special <= 1'b0;
            buffered     <= 1'b0;
            master_sel   <= 1'b0;
            auto_eoi     <= 1'b0;
            cpu_mode     <= 1'b0;
        end else if (w4_hit) begin
            nest_special <= wdata[4];
            buffered     <= wdata[3];
            master_sel   <= wdata[2];
            auto_eoi     <= wdata[1];
            cpu_mode     <= wdata[0];
        end
    end

    assert_first_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        w1_hit |=> (level_mode == $past(wdata[B_LVL]) && single_mode == $past(wdata[B_SNGL])
                    && need4 == $past(wdata[B_NEED4])));

    assert_fourth_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !need4 |-> !(nest_special || buffered || master_sel || auto_eoi || cpu_mode));
endmodule

// File: rtl/pic_cfg_ops.sv
// Module: operating registers and readback. It holds the mask, the lowest-priority
// line, special mask and read selection, emits the end-of-interrupt/rotation
// strobe, and muxes host reads. Assumes hit strobes from the sequencer.
module pic_cfg_ops
    import pic_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w1_hit,
    input  logic              mask_hit,
    input  logic              rot_hit,
    input  logic              sel_hit,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     req_vec,
    input  logic [DW-1:0]     srv_vec,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     mask_bits,
    output logic [LVL_W-1:0]  lowest_prio,
    output logic              special_mask,
    output logic              rd_isr_sel,
    output logic              cmd_strobe,
    output logic [CODE_W-1:0] cmd_code,
    output logic [LVL_W-1:0]  cmd_level
);
    logic specific_rot;
    assign specific_rot = rot_hit && (wdata[7:6] == 2'b11);

    // purpose: mask register, cleared by a first byte, loaded after init
    always_ff @(posedge clk) begin
        if (!rst_n || w1_hit) mask_bits <= '0;
        else if (mask_hit)    mask_bits <= wdata;
    end

    // purpose: lowest-priority line, defaulted to the last line
    always_ff @(posedge clk) begin
        if (!rst_n || w1_hit)  lowest_prio <= LOWEST_DEFAULT;
        else if (specific_rot) lowest_prio <= wdata[LVL_W-1:0];
    end

    // purpose: special mask and read selection from the selection command
    always_ff @(posedge clk) begin
        if (!rst_n || w1_hit) begin
            special_mask <= 1'b0;
            rd_isr_sel   <= 1'b0;
        end else if (sel_hit) begin
            if (wdata[6]) special_mask <= wdata[5];
            if (wdata[1]) rd_isr_sel   <= wdata[0];
        end
    end

    // purpose: one-cycle command strobe with held code and level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= 1'b0;
            cmd_code   <= '0;
            cmd_level  <= '0;
        end else begin
            cmd_strobe <= rot_hit;
            if (rot_hit) begin
                cmd_code  <= wdata[DW-1:DW-CODE_W];
                cmd_level <= wdata[LVL_W-1:0];
            end
        end
    end

    // purpose: host readback mux
    always_comb begin
        if (addr)            rdata = mask_bits;
        else if (rd_isr_sel) rdata = srv_vec;
        else                 rdata = req_vec;
    end

    assert_defaults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        w1_hit |=> (mask_bits == '0 && lowest_prio == LOWEST_DEFAULT && !special_mask && !rd_isr_sel));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_hit && !w1_hit) |=> $stable(mask_bits));

    assert_rotate_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_hit && wdata[7:6] == 2'b11) |=> (lowest_prio == $past(wdata[LVL_W-1:0]) && cmd_strobe));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && !rot_hit) |=> !cmd_strobe);
endmodule

// File: rtl/pic_cfg_front.sv
// Module: top of the host front end. It ties the sequencer, the initialization
// registers and the operating registers together. Assumes a single host bus
// with one address bit and combinational reads.
module pic_cfg_front
    import pic_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     req_vec,
    input  logic [DW-1:0]     srv_vec,
    output logic [DW-1:0]     rdata,
    output logic              init_done,
    output logic              level_mode,
    output logic              intv4,
    output logic              single_mode,
    output logic [VB_W-1:0]   vec_base,
    output logic [DW-1:0]     casc_cfg,
    output logic              nest_special,
    output logic              buffered,
    output logic              master_sel,
    output logic              auto_eoi,
    output logic              cpu_mode,
    output logic [DW-1:0]     mask_bits,
    output logic [LVL_W-1:0]  lowest_prio,
    output logic              special_mask,
    output logic              rd_isr_sel,
    output logic              cmd_strobe,
    output logic [CODE_W-1:0] cmd_code,
    output logic [LVL_W-1:0]  cmd_level
);
    seq_state_t state;
    logic w1_hit, w2_hit, w3_hit, w4_hit, mask_hit, rot_hit, sel_hit;
    logic need4;

    pic_cfg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .dsel(wdata[B_FIRST:B_FIRST-1]), .single_mode(single_mode), .need4(need4),
        .state(state), .w1_hit(w1_hit), .w2_hit(w2_hit), .w3_hit(w3_hit),
        .w4_hit(w4_hit), .mask_hit(mask_hit), .rot_hit(rot_hit), .sel_hit(sel_hit)
    );

    pic_cfg_init_regs u_init (
        .clk(clk), .rst_n(rst_n), .w1_hit(w1_hit), .w2_hit(w2_hit),
        .w3_hit(w3_hit), .w4_hit(w4_hit), .wdata(wdata),
        .level_mode(level_mode), .intv4(intv4), .single_mode(single_mode),
        .need4(need4), .vec_base(vec_base), .casc_cfg(casc_cfg),
        .nest_special(nest_special), .buffered(buffered), .master_sel(master_sel),
        .auto_eoi(auto_eoi), .cpu_mode(cpu_mode)
    );

    pic_cfg_ops u_ops (
        .clk(clk), .rst_n(rst_n), .w1_hit(w1_hit), .mask_hit(mask_hit),
        .rot_hit(rot_hit), .sel_hit(sel_hit), .addr(addr), .wdata(wdata),
        .req_vec(req_vec), .srv_vec(srv_vec), .rdata(rdata),
        .mask_bits(mask_bits), .lowest_prio(lowest_prio), .special_mask(special_mask),
        .rd_isr_sel(rd_isr_sel), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .cmd_level(cmd_level)
    );

    assign init_done = (state == S_READY);

    assert_no_cmd_before_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !(wr_en && !addr && wdata[B_FIRST])) |=> !cmd_strobe);
endmodule

// File: tb/pic_cfg_front_test.sv
// Bench: directed series plus seeded random writes, checked after every
// write against a bench-side model of the requirements.
module pic_cfg_front_test;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic addr = 1'b0;
    logic [7:0] wdata = '0, req_vec = '0, srv_vec = '0;
    logic [7:0] rdata, casc_cfg, mask_bits;
    logic init_done, level_mode, intv4, single_mode, nest_special, buffered;
    logic master_sel, auto_eoi, cpu_mode, special_mask, rd_isr_sel, cmd_strobe;
    logic [4:0] vec_base;
    logic [2:0] lowest_prio, cmd_code, cmd_level;

    int n_cmp = 0, n_bad = 0;

    // bench model
    int m_st = 0; // 0 uninit,1 wait2,2 wait3,3 wait4,4 ready
    logic e_lvl = 0, e_iv = 0, e_sg = 0, e_n4 = 0, e_nest = 0, e_buf = 0, e_ms = 0;
    logic e_aeoi = 0, e_cpu = 0, e_smm = 0, e_risr = 0, e_stb = 0;
    logic [4:0] e_vb = 0;
    logic [7:0] e_casc = 0, e_mask = 0;
    logic [2:0] e_low = 3'd7, e_code = 0, e_clvl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cfg_front uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .req_vec(req_vec), .srv_vec(srv_vec), .rdata(rdata), .init_done(init_done),
        .level_mode(level_mode), .intv4(intv4), .single_mode(single_mode),
        .vec_base(vec_base), .casc_cfg(casc_cfg), .nest_special(nest_special),
        .buffered(buffered), .master_sel(master_sel), .auto_eoi(auto_eoi),
        .cpu_mode(cpu_mode), .mask_bits(mask_bits), .lowest_prio(lowest_prio),
        .special_mask(special_mask), .rd_isr_sel(rd_isr_sel), .cmd_strobe(cmd_strobe),
        .cmd_code(cmd_code), .cmd_level(cmd_level)
    );

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void clear_fourth();
        e_nest = 0; e_buf = 0; e_ms = 0; e_aeoi = 0; e_cpu = 0;
    endfunction

    // model of one host write, per R1..R9 and R11
    function automatic void model_write(input logic a, input logic [7:0] d);
        e_stb = 0;
        if (!a && d[4]) begin                       // R1 R2 R3
            e_lvl = d[3]; e_iv = d[2]; e_sg = d[1]; e_n4 = d[0];
            e_mask = 0; e_low = 3'd7; e_casc = 8'h07; e_smm = 0; e_risr = 0;
            clear_fourth(); m_st = 1;
        end else if (a) begin
            case (m_st)
                1: begin e_vb = d[7:3]; m_st = !e_sg ? 2 : (e_n4 ? 3 : 4); end      // R4
                2: begin e_casc = d; m_st = e_n4 ? 3 : 4; end                      // R5
                3: begin e_nest = d[4]; e_buf = d[3]; e_ms = d[2]; e_aeoi = d[1];
                         e_cpu = d[0]; m_st = 4; end                               // R6
                4: e_mask = d;                                                     // R7
                default: ;
            endcase
        end else if (m_st == 4) begin
            if (d[4:3] == 2'b00) begin                  // R8
                e_stb = 1; e_code = d[7:5]; e_clvl = d[2:0];
                if (d[7:6] == 2'b11) e_low = d[2:0];
            end else if (d[4:3] == 2'b01) begin         // R9
                if (d[6]) e_smm = d[5];
                if (d[1]) e_risr = d[0];
            end
        end
    endfunction

    task automatic check_all();
        cmp("R1 init_done", {7'd0, init_done}, {7'd0, m_st == 4});
        cmp("R2 level_mode", {7'd0, level_mode}, {7'd0, e_lvl});
        cmp("R2 intv4", {7'd0, intv4}, {7'd0, e_iv});
        cmp("R2 single_mode", {7'd0, single_mode}, {7'd0, e_sg});
        cmp("R4 vec_base", {3'd0, vec_base}, {3'd0, e_vb});
        cmp("R5 casc_cfg", casc_cfg, e_casc);
        cmp("R6 fourth fields", {3'd0, nest_special, buffered, master_sel, auto_eoi, cpu_mode},
            {3'd0, e_nest, e_buf, e_ms, e_aeoi, e_cpu});
        cmp("R7 mask_bits", mask_bits, e_mask);
        cmp("R3 lowest_prio", {5'd0, lowest_prio}, {5'd0, e_low});
        cmp("R9 special_mask", {7'd0, special_mask}, {7'd0, e_smm});
        cmp("R9 rd_isr_sel", {7'd0, rd_isr_sel}, {7'd0, e_risr});
        cmp("R8 R11 cmd_strobe", {7'd0, cmd_strobe}, {7'd0, e_stb});
        cmp("R8 cmd_code", {5'd0, cmd_code}, {5'd0, e_code});
        cmp("R8 cmd_level", {5'd0, cmd_level}, {5'd0, e_clvl});
    endtask

    // write at a falling edge, sample at the next falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
        check_all();
    endtask

    task automatic rd_check(input logic [7:0] rq, input logic [7:0] sv);
        req_vec = rq; srv_vec = sv;
        addr = 1'b1; #1;
        cmp("R10 rdata mask", rdata, e_mask);
        addr = 1'b0; #1;
        cmp("R10 rdata status", rdata, e_risr ? sv : rq);
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();                                // reset state
        // R11/R7: writes before any first byte are ignored
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'hE4);
        wr(1'b0, 8'h6B);
        // single, level, interval 4, fourth byte needed
        wr(1'b0, 8'h1F);
        wr(1'b0, 8'h20);                            // R11 ignored mid-series
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h40);                            // R7 mask load
        wr(1'b0, 8'hE4);                            // R8 rotate level 4
        wr(1'b0, 8'h6A);                            // R9 request select
        rd_check(8'h5A, 8'hA5);
        wr(1'b0, 8'h6B);                            // R9 in-service select
        rd_check(8'h3C, 8'hC3);
        wr(1'b0, 8'h20);                            // R8 non-specific EOI
        // cascaded, fourth byte needed
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h48);
        wr(1'b1, 8'h0F);                            // R5 third byte
        wr(1'b1, 8'h1E);                            // R6 fourth byte
        // restart mid-series: cascaded, no fourth byte, fourth fields cleared
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h98);
        wr(1'b0, 8'h14);                            // R1 restart before third byte
        wr(1'b1, 8'hF0);
        wr(1'b1, 8'h0A);
        // single, no fourth byte: ready after second byte
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h81);                            // R7 now a mask load
        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [7:0] d;
            logic a;
            d = 8'($urandom());
            a = 1'($urandom());
            if ($urandom_range(0, 7) == 0) begin a = 1'b0; d[4] = 1'b1; end
            else if (!a && $urandom_range(0, 2) != 0) d[4] = 1'b0;
            wr(a, d);
            if (i % 16 == 0) rd_check(8'($urandom()), 8'($urandom()));
        end
        finish_up();
    end
endmodule